// File: doc/BRIEF.md
# Iterative Leading-Zero Counter

This block is a coprocessor unit that sits beside a processor datapath. It reports how many zero bits lie above the highest set bit of a 32-bit operand. It does not use a single-cycle priority encoder. It tests one bit per qualified clock, starting at the most significant bit, and stops at the first set bit. The time an operation takes therefore depends on the operand.

The processor raises `start_i` for one cycle and presents the operand on `dataa_i` in that same cycle. It must hold the operand steady until the operation completes. The unit raises `done_o` for one qualified cycle, and `result_o` is valid in that cycle. `clk_en_i` qualifies every clock edge: when it is low, the edge is ignored. `rst_ni` is an asynchronous, active-low whole-system reset.

Top module: `lzc_iter`

## Requirements
- R1: When the unit is idle, a qualified edge with `start_i` high captures `dataa_i` and begins a scan.
- R2: `result_o` equals the number of zero bits above the highest set bit of the operand. `done_o` rises on the (n+1)-th qualified edge after the start edge, where n is that count.
- R3: An edge with `clk_en_i` low changes nothing: scan progress, `done_o` and `result_o` all keep their values.
- R4: The operand 0x80000000 gives a result of 0, with `done_o` high after the first qualified edge following the start edge. This is the shortest operation.
- R5: The operand 0x00000001 gives a result of 31 after 32 qualified edges. This is the longest operation for a non-zero operand.
- R6: The operand 0 gives a result of 32 after 32 qualified edges.
- R7: `done_o` stays high for exactly one qualified cycle. `result_o` keeps its value from that cycle until the next operation completes.
- R8: A `start_i` that arrives while a scan is in progress is ignored: the running scan finishes at its original time with its original result.
- R9: While `rst_ni` is low, `done_o` and `result_o` read 0 and the unit returns to idle. No `done_o` appears afterwards without a new `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Qualifier for each clock edge; when low, the edge is ignored |
| start_i | input | 1 | Begins an operation on the current operand |
| dataa_i | input | 32 | Operand, held stable until `done_o` |
| result_o | output | 32 | Count of leading zeros, 0 to 32 |
| done_o | output | 1 | One-cycle completion flag; `result_o` is valid while it is high |

## Verification
The operands are chosen as follows:
- A single set top bit, a lone bottom bit and an all-zero word separate the early-exit path from the full 32-step path and from the special result of 32.
- Operands with a set bit in the middle, including cases with further set bits below it, show that the scan stops at the first one and ignores the lower bits.
- The same operands are also run with `clk_en_i` toggled or held low for a stretch. This confirms that only qualified edges count toward latency.
- A repeated `start_i` during a scan and a reset in the middle of a scan show that neither one restarts the count or produces a stray completion.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } lzc_state_e;
endpackage

// File: rtl/lzc_ctrl.sv
module lzc_ctrl
  import lzc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic finish_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);
  lzc_state_e state_q, state_d;
  logic       done_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_BUSY);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)  state_d = ST_BUSY;
      ST_BUSY: if (finish_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else if (en_i) begin
      state_q <= state_d;
      done_q  <= step_o && finish_i;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/lzc_scan.sv
module lzc_scan #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] data_i,
  output logic         finish_o,
  output logic [W-1:0] result_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  shreg_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  res_q;
  logic          msb;

  assign msb      = shreg_q[W-1];
  // stop on first one, or after testing the lowest bit
  assign finish_o = step_i && (msb || (cnt_q == LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
    end else if (en_i) begin
      if (load_i) begin
        shreg_q <= data_i;
        cnt_q   <= '0;
      end else if (step_i) begin
        shreg_q <= shreg_q << 1;
        cnt_q   <= cnt_q + 1'b1;
        if (finish_o) res_q <= msb ? W'(cnt_q) : W'(W);
      end
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/lzc_iter.sv
module lzc_iter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clk_en_i,
  input  logic         start_i,
  input  logic [W-1:0] dataa_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  logic load, step, finish;

  lzc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (clk_en_i),
    .start_i  (start_i),
    .finish_i (finish),
    .load_o   (load),
    .step_o   (step),
    .done_o   (done_o)
  );

  lzc_scan #(.W(W)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (clk_en_i),
    .load_i   (load),
    .step_i   (step),
    .data_i   (dataa_i),
    .finish_o (finish),
    .result_o (result_o)
  );
endmodule

// File: rtl/lzc_iter_chk.sv
module lzc_iter_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clk_en_i,
  input logic [W-1:0] dataa_i,
  input logic [W-1:0] result_o,
  input logic         done_o
);
  localparam logic [W-1:0] TOP = W'(W - 1);
  localparam logic [W-1:0] ALL = W'(W);

  a_r3_idle_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(result_o) && $stable(done_o)));

  a_r7_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && clk_en_i) |=> !done_o);

  a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  a_r6_zero_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == ALL) |-> (dataa_i == '0));

  a_r2_first_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o <= TOP) |-> ((dataa_i >> (TOP - result_o)) == W'(1)));

  a_r2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o <= ALL));
endmodule

bind lzc_iter lzc_iter_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_en_i (clk_en_i),
  .dataa_i  (dataa_i),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/lzc_iter_tb.sv
module lzc_iter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_i = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] dataa_i = '0;
  logic [31:0] result_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  lzc_iter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .start_i(start_i),
    .dataa_i(dataa_i), .result_o(result_o), .done_o(done_o)
  );

  function automatic int ref_lz(input logic [31:0] v);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return 32;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // mode 0: clk_en always high; 1: low on every other edge; 2: low for 5 edges after the 3rd
  task automatic run_op(input string req, input logic [31:0] v, input int mode,
                        input bit restart_mid);
    int edges = 0;
    int cyc = 0;
    int exp_lz = ref_lz(v);
    int exp_edges = (exp_lz == 32) ? 32 : exp_lz + 1;
    @(negedge clk_i);
    start_i = 1'b1; dataa_i = v; clk_en_i = 1'b1;
    tick();
    check({req, " R1 no early done"}, {31'd0, done_o}, 32'd0);
    while (cyc < 300) begin
      @(negedge clk_i);
      start_i = restart_mid && (edges == 3);
      case (mode)
        1: clk_en_i = cyc[0];
        2: clk_en_i = !(cyc >= 3 && cyc < 8);
        default: clk_en_i = 1'b1;
      endcase
      tick();
      cyc++;
      if (clk_en_i) edges++;
      if (done_o) break;
    end
    start_i = 1'b0;
    check({req, " R2 latency"}, edges, exp_edges);
    check({req, " R2 result"}, result_o, exp_lz);
    // done must drop on the next qualified edge, result held
    @(negedge clk_i); clk_en_i = 1'b1;
    tick();
    check({req, " R7 done pulse"}, {31'd0, done_o}, 32'd0);
    check({req, " R7 result hold"}, result_o, exp_lz);
  endtask

  task automatic t_reset_state();
    check("R9 reset done", {31'd0, done_o}, 32'd0);
    check("R9 reset result", result_o, 32'd0);
  endtask

  task automatic t_corner();
    run_op("R4 top bit", 32'h8000_0000, 0, 1'b0);
    run_op("R5 bottom bit", 32'h0000_0001, 0, 1'b0);
    run_op("R6 zero", 32'h0000_0000, 0, 1'b0);
  endtask

  task automatic t_patterns();
    run_op("R2 mid", 32'h0001_0000, 0, 1'b0);
    run_op("R2 tail bits", 32'h0013_ffff, 0, 1'b0);
    run_op("R2 ones", 32'hffff_ffff, 0, 1'b0);
    run_op("R2 bit 30", 32'h4000_0001, 0, 1'b0);
  endtask

  task automatic t_clk_en();
    run_op("R3 toggled", 32'h0000_0100, 1, 1'b0);
    run_op("R3 gap", 32'h0000_0000, 2, 1'b0);
    // done held while clk_en low
    @(negedge clk_i); start_i = 1'b1; dataa_i = 32'h8000_0000; clk_en_i = 1'b1;
    tick();
    @(negedge clk_i); start_i = 1'b0;
    tick();
    check("R3 done seen", {31'd0, done_o}, 32'd1);
    @(negedge clk_i); clk_en_i = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    check("R3 done frozen", {31'd0, done_o}, 32'd1);
    check("R3 result frozen", result_o, 32'd0);
    @(negedge clk_i); clk_en_i = 1'b1;
    tick();
    check("R3 done clears", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_restart();
    run_op("R8 restart ignored", 32'h0000_0001, 0, 1'b1);
  endtask

  task automatic t_mid_reset();
    bit seen = 1'b0;
    @(negedge clk_i); start_i = 1'b1; dataa_i = 32'h0000_0004; clk_en_i = 1'b1;
    tick();
    @(negedge clk_i); start_i = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check("R9 mid reset done", {31'd0, done_o}, 32'd0);
    check("R9 mid reset result", result_o, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (done_o) seen = 1'b1;
    end
    check("R9 idle after reset", {31'd0, seen}, 32'd0);
    run_op("R9 op after reset", 32'h0000_0400, 0, 1'b0);
  endtask

  initial begin
    #1;
    t_reset_state();
    #30;
    @(negedge clk_i); rst_ni = 1'b1; clk_en_i = 1'b1;
    tick();
    t_reset_state();
    t_corner();
    t_patterns();
    t_clk_en();
    t_restart();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule